// File: doc/BRIEF.md
# Two-Descriptor Alternating DMA Channel

This block is one DMA channel that moves 32-bit words between memory and a single peripheral word port. Two buffer descriptors, A and B, each hold a start address and a word count. The channel drains the descriptor chosen by a hardware buffer-select bit. When that count reaches zero, it marks the buffer finished, withdraws its start flag and flips the select bit. It then continues with the other descriptor if that descriptor has been armed. Software can therefore refill one descriptor while the other is in flight.

Software sees eight word registers, addressed by `reg_addr`:
- 0: device configuration. Bit 0 selects the direction: 0 moves data from memory to the peripheral, 1 moves data from the peripheral to memory. Bits 31:1 are presented on `periph_id`.
- 1: control set.
- 2: control clear.
- 3: control read.
- 4 and 5: buffer A address and count.
- 6 and 7: buffer B address and count.

The control word has these bits:

| Bit | Name | Meaning |
|---|---|---|
| 0 | RUN | the channel may transfer |
| 1 | IE | interrupt enable |
| 2 | ERR | a memory access failed |
| 3 | FINA | buffer A finished |
| 4 | ARMA | buffer A armed |
| 5 | FINB | buffer B finished |
| 6 | ARMB | buffer B armed |
| 7 | SEL | buffer in use; 0 = A, 1 = B; hardware only |

The sequencer has five states:
- IDLE waits for work. It takes transition *launch* to FETCH or PULL, and transition *retire* (stay in IDLE) when the selected count is zero.
- FETCH requests a memory read. It takes *got* to PUSH, or *fault* to IDLE.
- PUSH offers the word to the peripheral. It takes *sent* to IDLE.
- PULL accepts a word from the peripheral. It takes *took* to STORE.
- STORE requests a memory write. It takes *put* or *fault* to IDLE.

Every non-idle state also takes *halt* to IDLE when RUN is low.

Top module: `pingpong_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is low and no request or handshake output is active.
- R2: A write to address 1 sets, and a write to address 2 clears, each control bit 0..6 whose data bit is 1. Zero bits leave a bit unchanged. Bit 7 (SEL) ignores both writes. Address 3 returns the control word, and addresses 1 and 2 read 0.
- R3: With direction 0, each word is read from memory at the selected address and held stable on `tx_data` with `tx_valid` until `tx_ready`. The address register then advances by 4 and the count by -1.
- R4: With direction 1, each word accepted on the receive port is written to memory at the selected address, with the same address and count progression.
- R5: When the selected count is zero and the buffer is armed, the channel sets that buffer's finish bit, clears its arm bit and flips SEL. It then proceeds with the other buffer if that buffer is armed and RUN is set.
- R6: No transfer starts while the buffer selected by SEL is unarmed, even if the other buffer is armed. A buffer armed with count 0 retires without any beat.
- R7: `irq` is high exactly while IE is set and any of ERR, FINA or FINB is set. Clearing those three bits drops it in the next cycle.
- R8: The cycle after RUN is cleared, no request or handshake output is active. The selected descriptor keeps the address and count of its last completed beat, and setting RUN again resumes from there.
- R9: A memory error response sets ERR and does not advance the descriptor. The channel stays stalled while ERR is set, even with RUN set.
- R10: Count registers are 13 bits wide, so writing 0xFFFF reads back 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr` |
| irq | output | 1 | interrupt request |
| periph_id | output | 31 | peripheral identifier from the device configuration |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | memory request is a write |
| mem_addr | output | 32 | memory word address |
| mem_wdata | output | 32 | memory write data |
| mem_gnt | input | 1 | memory grant; the response is valid in the same cycle |
| mem_rdata | input | 32 | memory read data |
| mem_err | input | 1 | memory error response, valid with the grant |
| tx_valid | output | 1 | word offered to the peripheral |
| tx_data | output | 32 | word to the peripheral |
| tx_ready | input | 1 | peripheral accepts the word |
| rx_valid | input | 1 | peripheral offers a word |
| rx_data | input | 32 | word from the peripheral |
| rx_ready | output | 1 | channel accepts the word |

## Verification
Register writes reach the read port one cycle later, and the bench reads them back on the following falling edge. Halting and clearing interrupt flags act on the outputs in the cycle right after the write's edge, so those checks sample at the first falling edge after it. A beat takes three cycles when the grant and the peripheral respond at once, plus one idle cycle to retire a buffer. Transfer results are therefore checked only after a window of several times that length, once the channel has gone quiet. Over that window the bench also confirms that no extra words moved.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;
    localparam int WORD_W = 32;
    localparam int NBUF   = 2;
    localparam int CSR_W  = 8;

    localparam int B_RUN  = 0;
    localparam int B_IE   = 1;
    localparam int B_ERR  = 2;
    localparam int B_FINA = 3;
    localparam int B_ARMA = 4;
    localparam int B_FINB = 5;
    localparam int B_ARMB = 6;
    localparam int B_SEL  = 7;

    localparam logic [CSR_W-1:0] SW_MASK = 8'h7F;

    localparam logic [2:0] RA_DEV  = 3'd0;
    localparam logic [2:0] RA_SET  = 3'd1;
    localparam logic [2:0] RA_CLR  = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_AADR = 3'd4;
    localparam logic [2:0] RA_ACNT = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUSH,
        ST_PULL,
        ST_STORE
    } seq_state_t;

    function automatic int fin_bit(input logic sel);
        return sel ? B_FINB : B_FINA;
    endfunction

    function automatic int arm_bit(input logic sel);
        return sel ? B_ARMB : B_ARMA;
    endfunction
endpackage

// File: rtl/pingpong_dma_regs.sv
module pingpong_dma_regs
    import pingpong_dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 13,
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              beat_done,
    input  logic              buf_finish,
    input  logic              err_set,
    output logic              run,
    output logic              err,
    output logic              dir,
    output logic              arm_act,
    output logic [AW-1:0]     act_addr,
    output logic [CW-1:0]     act_cnt,
    output logic              irq,
    output logic [WORD_W-2:0] periph_id
);
    logic [CSR_W-1:0]  csr_q, csr_hw, csr_d;
    logic [WORD_W-1:0] dev_q;
    logic [AW-1:0]     d_addr [NBUF];
    logic [CW-1:0]     d_cnt  [NBUF];
    logic              sel;

    assign sel = csr_q[B_SEL];

    always_comb begin
        csr_hw = csr_q;
        if (err_set) begin
            csr_hw[B_ERR] = 1'b1;
        end
        if (buf_finish) begin
            csr_hw[fin_bit(sel)] = 1'b1;
            csr_hw[arm_bit(sel)] = 1'b0;
            csr_hw[B_SEL]        = ~sel;
        end
        csr_d = csr_hw;
        if (we && addr == RA_SET) begin
            csr_d = csr_d | (wdata[CSR_W-1:0] & SW_MASK);
        end
        if (we && addr == RA_CLR) begin
            csr_d = csr_d & ~(wdata[CSR_W-1:0] & SW_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
            dev_q <= '0;
        end else begin
            csr_q <= csr_d;
            if (we && addr == RA_DEV) begin
                dev_q <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_desc
        localparam logic [2:0] IDX_A = 3'(RA_AADR + 2 * g);
        localparam logic [2:0] IDX_C = 3'(RA_ACNT + 2 * g);
        logic mine;
        assign mine = (sel == 1'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_addr[g] <= '0;
                d_cnt[g]  <= '0;
            end else begin
                if (we && addr == IDX_A) begin
                    d_addr[g] <= wdata[AW-1:0];
                end else if (beat_done && mine) begin
                    d_addr[g] <= d_addr[g] + AW'(STEP);
                end
                if (we && addr == IDX_C) begin
                    d_cnt[g] <= wdata[CW-1:0];
                end else if (beat_done && mine) begin
                    d_cnt[g] <= d_cnt[g] - CW'(1);
                end
            end
        end
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = dev_q;
            3'd3:    rdata = WORD_W'(csr_q);
            3'd4:    rdata = WORD_W'(d_addr[0]);
            3'd5:    rdata = WORD_W'(d_cnt[0]);
            3'd6:    rdata = WORD_W'(d_addr[1]);
            3'd7:    rdata = WORD_W'(d_cnt[1]);
            default: rdata = '0;
        endcase
    end

    assign run       = csr_q[B_RUN];
    assign err       = csr_q[B_ERR];
    assign dir       = dev_q[0];
    assign periph_id = dev_q[WORD_W-1:1];
    assign arm_act   = csr_q[arm_bit(sel)];
    assign act_addr  = d_addr[sel];
    assign act_cnt   = d_cnt[sel];
    assign irq       = csr_q[B_IE] & (csr_q[B_ERR] | csr_q[B_FINA] | csr_q[B_FINB]);
endmodule

// File: rtl/pingpong_dma_seq.sv
module pingpong_dma_seq
    import pingpong_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              err,
    input  logic              dir,
    input  logic              arm_act,
    input  logic [AW-1:0]     act_addr,
    input  logic [CW-1:0]     act_cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              beat_done,
    output logic              buf_finish,
    output logic              err_set
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    logic              go;

    assign go = run && !err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH && run && mem_gnt && !mem_err) begin
                hold_q <= mem_rdata;
            end else if (state_q == ST_PULL && run && rx_valid) begin
                hold_q <= rx_data;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        beat_done  = 1'b0;
        buf_finish = 1'b0;
        err_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go && arm_act) begin
                    if (act_cnt == '0) begin
                        buf_finish = 1'b1;
                    end else begin
                        state_d = dir ? ST_PULL : ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (mem_gnt) begin
                    err_set = mem_err;
                    state_d = mem_err ? ST_IDLE : ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (tx_ready) begin
                    beat_done = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_PULL: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (rx_valid) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (mem_gnt) begin
                    err_set   = mem_err;
                    beat_done = !mem_err;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = run && (state_q == ST_FETCH || state_q == ST_STORE);
        mem_we    = (state_q == ST_STORE);
        mem_addr  = act_addr;
        mem_wdata = hold_q;
        tx_valid  = run && (state_q == ST_PUSH);
        tx_data   = hold_q;
        rx_ready  = run && (state_q == ST_PULL);
    end
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pingpong_dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 13,
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic [WORD_W-2:0] periph_id,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready
);
    logic          run, err, dir, arm_act;
    logic          beat_done, buf_finish, err_set;
    logic [AW-1:0] act_addr;
    logic [CW-1:0] act_cnt;

    pingpong_dma_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .beat_done(beat_done), .buf_finish(buf_finish), .err_set(err_set),
        .run(run), .err(err), .dir(dir), .arm_act(arm_act),
        .act_addr(act_addr), .act_cnt(act_cnt),
        .irq(irq), .periph_id(periph_id)
    );

    pingpong_dma_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .run(run), .err(err), .dir(dir), .arm_act(arm_act),
        .act_addr(act_addr), .act_cnt(act_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .beat_done(beat_done), .buf_finish(buf_finish), .err_set(err_set)
    );
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [31:0]   tx_data,
    input logic          rx_ready
);
    // R8: halting takes effect in the very next cycle
    a_r8_halt_next: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd2 && reg_wdata[0]) |=> (!mem_req && !tx_valid && !rx_ready));

    // R7: clearing all three flag bits drops the interrupt
    a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd2 && reg_wdata[2] && reg_wdata[3] && reg_wdata[5]) |=> !irq);

    // R3: offered word held until accepted
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (!tx_valid || $stable(tx_data)));

    // R3: memory address held while waiting for grant
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !reg_we) |=> (!mem_req || $stable(mem_addr)));

    // R1: one beat phase at a time
    a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, tx_valid, rx_ready}));
endmodule

bind pingpong_dma pingpong_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_ready(rx_ready)
);

// File: tb/pingpong_dma_test.sv
module pingpong_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SCR = 32'hA5A5_0000;

    typedef struct packed {
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [2:0]  ra;
        logic [31:0] ex;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{3'd0, 32'h1234_5679, 3'd0, 32'h1234_5679},
        '{3'd1, 32'h0000_0042, 3'd3, 32'h0000_0042},
        '{3'd1, 32'h0000_0080, 3'd3, 32'h0000_0042},
        '{3'd2, 32'h0000_0040, 3'd3, 32'h0000_0002},
        '{3'd2, 32'h0000_0000, 3'd3, 32'h0000_0002},
        '{3'd1, 32'h0000_0000, 3'd1, 32'h0000_0000},
        '{3'd5, 32'h0000_FFFF, 3'd5, 32'h0000_1FFF},
        '{3'd6, 32'hDEAD_BEE0, 3'd6, 32'hDEAD_BEE0},
        '{3'd2, 32'h0000_00FF, 3'd3, 32'h0000_0000},
        '{3'd0, 32'h0000_0000, 3'd2, 32'h0000_0000}
    };

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic irq;
    logic [30:0] periph_id;
    logic mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic tx_valid, tx_ready = 0, rx_valid, rx_ready;
    logic [31:0] tx_data, rx_data;
    logic gnt_en = 1, err_en = 0, rx_en = 0, clr_log = 0;
    logic [31:0] err_addr = 0;
    logic [31:0] tx_log [16];
    logic [31:0] wa_log [16];
    logic [31:0] wd_log [16];
    int tx_n = 0, wr_n = 0, rx_n = 0;
    int checks = 0, fails = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = mem_addr ^ SCR;
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign rx_valid  = rx_en;
    assign rx_data   = 32'hD000_0000 + 32'(rx_n);

    always @(posedge clk) begin
        if (clr_log) begin
            tx_n <= 0; wr_n <= 0; rx_n <= 0;
        end else begin
            if (tx_valid && tx_ready) begin
                tx_log[tx_n & 15] <= tx_data; tx_n <= tx_n + 1;
            end
            if (mem_req && mem_we && mem_gnt && !mem_err) begin
                wa_log[wr_n & 15] <= mem_addr; wd_log[wr_n & 15] <= mem_wdata; wr_n <= wr_n + 1;
            end
            if (rx_valid && rx_ready) rx_n <= rx_n + 1;
        end
    end

    pingpong_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .periph_id(periph_id),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_logs();
        @(negedge clk); clr_log = 1;
        @(negedge clk); clr_log = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), rv); check("R1 register reset", rv, 0);
        end
        check("R1 irq reset", 32'(irq), 0);
        check("R1 no request", 32'({mem_req, tx_valid, rx_ready}), 0);

        // R2 and R10 register vectors
        for (int i = 0; i < 10; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            rd(TBL[i].ra, rv);
            check("R2/R10 table", rv, TBL[i].ex);
        end

        // R3 memory to peripheral, buffer A of 3 words
        wr(3'd4, 32'h100); wr(3'd5, 3); tx_ready = 1;
        clear_logs();
        wr(3'd1, 32'h13);
        idle(30);
        check("R3 word count", 32'(tx_n), 3);
        for (int i = 0; i < 3; i++) check("R3 word data", tx_log[i], (32'h100 + 32'(4 * i)) ^ SCR);
        rd(3'd3, rv); check("R5 status after A", rv, 32'h8B);
        rd(3'd4, rv); check("R3 address advanced", rv, 32'h10C);
        rd(3'd5, rv); check("R3 count exhausted", rv, 0);
        check("R7 irq on finish", 32'(irq), 1);

        // R7 interrupt gating
        wr(3'd2, 32'h02); check("R7 irq masked", 32'(irq), 0);
        wr(3'd1, 32'h02); check("R7 irq unmasked", 32'(irq), 1);
        wr(3'd2, 32'h2C); check("R7 irq cleared", 32'(irq), 0);

        // R6 selected buffer (B) unarmed: no transfer despite A armed
        wr(3'd4, 32'h200); wr(3'd5, 2); wr(3'd7, 0);
        clear_logs();
        wr(3'd1, 32'h10);
        idle(15);
        check("R6 idle while SEL unarmed", 32'(tx_n), 0);
        rd(3'd4, rv); check("R6 A untouched", rv, 32'h200);
        wr(3'd1, 32'h40);
        idle(30);
        check("R6 zero-count B retires then A runs", 32'(tx_n), 2);
        check("R6 first A word", tx_log[0], 32'h200 ^ SCR);
        check("R6 second A word", tx_log[1], 32'h204 ^ SCR);
        rd(3'd3, rv); check("R6 status", rv, 32'hAB);

        // R5 both armed, B selected first
        wr(3'd2, 32'h28);
        wr(3'd6, 32'h300); wr(3'd7, 2); wr(3'd4, 32'h400); wr(3'd5, 1);
        clear_logs();
        wr(3'd1, 32'h50);
        idle(40);
        check("R5 chained words", 32'(tx_n), 3);
        check("R5 order B0", tx_log[0], 32'h300 ^ SCR);
        check("R5 order B1", tx_log[1], 32'h304 ^ SCR);
        check("R5 order A0", tx_log[2], 32'h400 ^ SCR);
        rd(3'd3, rv); check("R5 status", rv, 32'hAB);

        // R8 halt and resume on buffer B
        wr(3'd2, 32'h28);
        tx_ready = 0;
        wr(3'd6, 32'h500); wr(3'd7, 4);
        clear_logs();
        wr(3'd1, 32'h40);
        idle(8);
        check("R8 stalled offer", 32'(tx_valid), 1);
        wr(3'd2, 32'h01);
        check("R8 outputs quiet", 32'({mem_req, tx_valid, rx_ready}), 0);
        rd(3'd6, rv); check("R8 address kept", rv, 32'h500);
        rd(3'd7, rv); check("R8 count kept", rv, 4);
        tx_ready = 1;
        idle(10);
        check("R8 no beat while halted", 32'(tx_n), 0);
        wr(3'd1, 32'h01);
        idle(40);
        check("R8 resumed words", 32'(tx_n), 4);
        check("R8 resumed first word", tx_log[0], 32'h500 ^ SCR);
        rd(3'd3, rv); check("R8 status", rv, 32'h23);

        // R9 memory error on third word of A
        wr(3'd2, 32'h28);
        wr(3'd4, 32'h600); wr(3'd5, 4);
        err_addr = 32'h608; err_en = 1;
        clear_logs();
        wr(3'd1, 32'h10);
        idle(40);
        check("R9 words before fault", 32'(tx_n), 2);
        rd(3'd3, rv); check("R9 status", rv, 32'h17);
        check("R9 irq on error", 32'(irq), 1);
        rd(3'd4, rv); check("R9 address not advanced", rv, 32'h608);
        rd(3'd5, rv); check("R9 count not advanced", rv, 2);
        err_en = 0;
        idle(10);
        check("R9 stalled while ERR", 32'(tx_n), 2);
        wr(3'd2, 32'h05); wr(3'd1, 32'h01);
        idle(30);
        check("R9 restart words", 32'(tx_n), 4);
        check("R9 restart data", tx_log[2], 32'h608 ^ SCR);
        rd(3'd3, rv); check("R9 final status", rv, 32'h8B);

        // R4 peripheral to memory on buffer B
        wr(3'd2, 32'h28);
        wr(3'd0, 32'h1);
        wr(3'd6, 32'h700); wr(3'd7, 3);
        rx_en = 1;
        clear_logs();
        wr(3'd1, 32'h40);
        idle(40);
        check("R4 store count", 32'(wr_n), 3);
        check("R4 pulls", 32'(rx_n), 3);
        for (int i = 0; i < 3; i++) begin
            check("R4 store address", wa_log[i], 32'h700 + 32'(4 * i));
            check("R4 store data", wd_log[i], 32'hD000_0000 + 32'(i));
        end
        rd(3'd3, rv); check("R4 status", rv, 32'h23);

        finish_run();
    end
endmodule